// File: doc/BRIEF.md
# Pipeline Issue Timing Controller

This block reproduces the issue-stage timing of an in-order pipelined processor without doing any of the real work. Each cycle it looks at one presented instruction descriptor. The descriptor holds a class code, a flag that marks a read of a late-result value, branch outcome flags and a shift amount. From these the block decides whether the slot is taken, held back by a stall, delayed by a hazard bubble, or discarded by a flush. As a result the total cycle count of a program follows a fixed per-class cost table.

The block holds every instruction's cost internally. An external bus-busy input stretches memory-class instructions for as long as their bus transfers last. Two counters report progress: one counts retired instructions and one counts active cycles. A static feature mask and a multiplier-kind parameter select the variants of the cost table.

Top module: `issue_timing_ctrl`

## Requirements
- R1: An instruction is retired when `in_ready` is high and `cancel` is low. `retired_cnt` grows by exactly one per retired instruction. ALU (class 0), single-cycle custom (1), control read (7), load (8) and store (9) cost one cycle when no bus transfer is pending.
- R2: `stall`, `bubble` and `cancel` are never high together. `in_ready` is low whenever `stall` or `bubble` is high.
- R3: Classes 2, 7, 8, 13, 14 and 15 produce late results. A following instruction with `ins_uses_late` set is delayed by bubbles so that exactly two free cycles separate it from the producer's last cycle. Any instruction issued in between counts toward those two cycles.
- R4: A branch (class 3) costs one cycle when predicted not taken and two when correctly predicted taken (`br_taken`=1, `br_mispredict`=0).
- R5: A direct call or jump, or a shadow read (class 4), costs two cycles. An indirect jump, return or call (class 5) costs three.
- R6: The exception/control-write class (6) flushes the pipeline. It costs four cycles when `FEATURE_MASK` is zero and five when any mask bit is set, and the cost includes three cancel slots.
- R7: After a flush, the next three free slots are cancel slots. In each of them, a valid instruction is consumed with `cancel` high and is not retired; an empty slot raises no `cancel`. A mispredicted branch costs four cycles.
- R8: Data-line flush (10) and data-line init (11) cost two cycles. Instruction-cache flush/init (12) costs four.
- R9: After a load, store or data-line flush has finished its base cycles, `stall` stays high while `bus_busy` is high. The next instruction is taken in the first cycle `bus_busy` is low.
- R10: A shift (15) costs one cycle with `MULT_KIND`=0, two cycles with `MULT_KIND`=1, and max(shift amount,1) cycles with `MULT_KIND`=2.
- R11: Multiply (13), divide (14) and multicycle custom (2) cost `MUL_CYC`, `DIV_CYC` and `CUSTOM_CYC` cycles.
- R12: Reset clears both counters, any pending cycles, the cancel window and pending late-result hazards.
- R13: `cycle_cnt` grows by one in every cycle where `ins_valid` is high or earlier work is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | A descriptor is presented |
| ins_class | input | 4 | Instruction class code |
| ins_uses_late | input | 1 | Reads the result of a recent late-result producer |
| br_taken | input | 1 | Branch predicted and resolved taken |
| br_mispredict | input | 1 | Branch prediction was wrong |
| shift_amt | input | 5 | Shift distance for class 15 |
| bus_busy | input | 1 | Bus transfer of a memory instruction still outstanding |
| in_ready | output | 1 | Presented slot consumed this cycle |
| stall | output | 1 | Earlier instruction still occupies the stage |
| bubble | output | 1 | Late-result hazard delays the presented instruction |
| cancel | output | 1 | Presented instruction is discarded by a flush |
| retired_cnt | output | CNT_W | Retired instruction count |
| cycle_cnt | output | CNT_W | Active cycle count |

## Verification
A late-result hazard can fall in the same cycles as another cost: a long shift or divide may stall the stage while its own result is still pending. A load's bus hold can likewise overlap the hazard window. The bench provokes this with a multi-cycle shift or divide immediately followed by a dependent instruction. It judges the overlap by the measured wait: the stall cycles must come first and the two bubbles only afterwards, so that the bubbles are not absorbed into the stall. Flush windows are also run with both valid and empty slots, to separate consumed-and-cancelled slots from idle ones.

// File: rtl/issue_timing_pkg.sv
// Package: shared class codes and multiplier-kind constants for the issue
// timing controller. Assumes a 4-bit class field; every code is used.
package issue_timing_pkg;

    typedef enum logic [3:0] {
        CLS_ALU     = 4'd0,
        CLS_CUST1   = 4'd1,
        CLS_CUSTN   = 4'd2,
        CLS_BRANCH  = 4'd3,
        CLS_CALL    = 4'd4,
        CLS_JIND    = 4'd5,
        CLS_EXC     = 4'd6,
        CLS_RDCTL   = 4'd7,
        CLS_LOAD    = 4'd8,
        CLS_STORE   = 4'd9,
        CLS_DFLUSH  = 4'd10,
        CLS_DINIT   = 4'd11,
        CLS_IFLUSH  = 4'd12,
        CLS_MUL     = 4'd13,
        CLS_DIV     = 4'd14,
        CLS_SHIFT   = 4'd15
    } ins_class_e;

    localparam int MK_EMBEDDED = 0;
    localparam int MK_LOGIC    = 1;
    localparam int MK_NONE     = 2;

endpackage

// File: rtl/issue_cost_decode.sv
// Module: issue_cost_decode
// Turns a descriptor into its timing attributes: extra occupancy cycles
// beyond the first, whether it flushes, whether it produces a late result,
// and whether it may hold on the bus. Purely combinational.
// Assumes the cycle parameters are at least 1 and fit in EXTRA_W bits.
module issue_cost_decode
    import issue_timing_pkg::*;
#(
    parameter logic [5:0] FEATURE_MASK = 6'b0,
    parameter int MULT_KIND  = MK_NONE,
    parameter int MUL_CYC    = 3,
    parameter int DIV_CYC    = 6,
    parameter int CUSTOM_CYC = 3,
    parameter int EXTRA_W    = 5
) (
    input  logic [3:0]         cls,
    input  logic               taken,
    input  logic               mispredict,
    input  logic [4:0]         shamt,
    output logic [EXTRA_W-1:0] extra,
    output logic               flush,
    output logic               late,
    output logic               mem
);

    localparam logic [EXTRA_W-1:0] ONE = EXTRA_W'(1);
    localparam logic [EXTRA_W-1:0] EXC_EXTRA = (FEATURE_MASK != 6'b0) ? ONE : '0;

    // Map the class (and its flags) to its cost attributes.
    always_comb begin
        extra = '0;
        flush = 1'b0;
        late  = 1'b0;
        mem   = 1'b0;
        case (ins_class_e'(cls))
            CLS_ALU, CLS_CUST1: ;
            CLS_CUSTN:  begin extra = EXTRA_W'(CUSTOM_CYC - 1); late = 1'b1; end
            CLS_BRANCH: begin
                if (mispredict) flush = 1'b1;
                else if (taken) extra = ONE;
            end
            CLS_CALL:   extra = ONE;
            CLS_JIND:   extra = EXTRA_W'(2);
            CLS_EXC:    begin extra = EXC_EXTRA; flush = 1'b1; end
            CLS_RDCTL:  late = 1'b1;
            CLS_LOAD:   begin late = 1'b1; mem = 1'b1; end
            CLS_STORE:  mem = 1'b1;
            CLS_DFLUSH: begin extra = ONE; mem = 1'b1; end
            CLS_DINIT:  extra = ONE;
            CLS_IFLUSH: extra = EXTRA_W'(3);
            CLS_MUL:    begin extra = EXTRA_W'(MUL_CYC - 1); late = 1'b1; end
            CLS_DIV:    begin extra = EXTRA_W'(DIV_CYC - 1); late = 1'b1; end
            CLS_SHIFT:  begin
                late = 1'b1;
                if (MULT_KIND == MK_LOGIC) extra = ONE;
                else if (MULT_KIND == MK_NONE && shamt > 5'd1)
                    extra = EXTRA_W'(shamt) - ONE;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/late_result_tracker.sv
// Module: late_result_tracker
// Counts the free cycles still owed after a late-result producer. A new
// producer reloads the count; each free cycle (no stall) uses one up.
// Assumes set and step are qualified by the caller.
module late_result_tracker #(
    parameter int GAP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic step,
    output logic pending
);

    localparam int GW = $clog2(GAP + 1);
    localparam logic [GW-1:0] GAP_V = GW'(GAP);

    logic [GW-1:0] owed;

    // Reload on a producer, otherwise count down on free cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)                  owed <= '0;
        else if (set)                owed <= GAP_V;
        else if (step && owed != '0) owed <= owed - GW'(1);
    end

    assign pending = (owed != '0);

endmodule

// File: rtl/issue_counters.sv
// Module: issue_counters
// Retired-instruction and active-cycle counters. Assumes the increment
// strobes are already qualified; wraps at 2**CNT_W.
module issue_counters #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retire,
    input  logic             active,
    output logic [CNT_W-1:0] retired_cnt,
    output logic [CNT_W-1:0] cycle_cnt
);

    // Count retirements and active cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            retired_cnt <= '0;
            cycle_cnt   <= '0;
        end else begin
            if (retire) retired_cnt <= retired_cnt + CNT_W'(1);
            if (active) cycle_cnt   <= cycle_cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/issue_timing_ctrl.sv
// Module: issue_timing_ctrl (top)
// Issue-stage timing model. Order of precedence in a cycle: occupancy
// stall, bus hold, flush cancel slot, late-result bubble, then issue.
// Assumes the descriptor is held stable until in_ready is seen.
module issue_timing_ctrl
    import issue_timing_pkg::*;
#(
    parameter logic [5:0] FEATURE_MASK = 6'b0,
    parameter int MULT_KIND   = MK_NONE,
    parameter int MUL_CYC     = 3,
    parameter int DIV_CYC     = 6,
    parameter int CUSTOM_CYC  = 3,
    parameter int FLUSH_SLOTS = 3,
    parameter int LATE_GAP    = 2,
    parameter int CNT_W       = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_valid,
    input  logic [3:0]       ins_class,
    input  logic             ins_uses_late,
    input  logic             br_taken,
    input  logic             br_mispredict,
    input  logic [4:0]       shift_amt,
    input  logic             bus_busy,
    output logic             in_ready,
    output logic             stall,
    output logic             bubble,
    output logic             cancel,
    output logic [CNT_W-1:0] retired_cnt,
    output logic [CNT_W-1:0] cycle_cnt
);

    localparam int MAX_A   = (DIV_CYC > MUL_CYC) ? DIV_CYC : MUL_CYC;
    localparam int MAX_B   = (MAX_A > CUSTOM_CYC) ? MAX_A : CUSTOM_CYC;
    localparam int MAX_LAT = (MAX_B > 32) ? MAX_B : 32;
    localparam int EXTRA_W = $clog2(MAX_LAT);
    localparam int WIN_W   = $clog2(FLUSH_SLOTS + 1);

    logic [EXTRA_W-1:0] dec_extra, rem_q;
    logic               dec_flush, dec_late, dec_mem;
    logic [WIN_W-1:0]   win_q;
    logic               hold_q;
    logic               free, win_slot, accept, hazard_pend;

    issue_cost_decode #(
        .FEATURE_MASK(FEATURE_MASK), .MULT_KIND(MULT_KIND),
        .MUL_CYC(MUL_CYC), .DIV_CYC(DIV_CYC), .CUSTOM_CYC(CUSTOM_CYC),
        .EXTRA_W(EXTRA_W)
    ) u_dec (
        .cls(ins_class), .taken(br_taken), .mispredict(br_mispredict),
        .shamt(shift_amt), .extra(dec_extra), .flush(dec_flush),
        .late(dec_late), .mem(dec_mem)
    );

    late_result_tracker #(.GAP(LATE_GAP)) u_late (
        .clk(clk), .rst_n(rst_n), .set(accept && dec_late),
        .step(free), .pending(hazard_pend)
    );

    issue_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .retire(accept),
        .active(ins_valid || !free || win_q != '0),
        .retired_cnt(retired_cnt), .cycle_cnt(cycle_cnt)
    );

    // Slot decision for the current cycle.
    always_comb begin
        free     = (rem_q == '0) && !(hold_q && bus_busy);
        win_slot = free && (win_q != '0);
        stall    = !free;
        cancel   = win_slot && ins_valid;
        bubble   = free && !win_slot && ins_valid && ins_uses_late && hazard_pend;
        accept   = free && !win_slot && ins_valid && !bubble;
        in_ready = accept || cancel;
    end

    // Occupancy, cancel window and bus-hold state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            win_q  <= '0;
            hold_q <= 1'b0;
        end else if (accept) begin
            rem_q  <= dec_extra;
            win_q  <= dec_flush ? WIN_W'(FLUSH_SLOTS) : '0;
            hold_q <= dec_mem;
        end else begin
            if (rem_q != '0) rem_q <= rem_q - EXTRA_W'(1);
            if (win_slot)    win_q <= win_q - WIN_W'(1);
            if (rem_q == '0 && !bus_busy) hold_q <= 1'b0;
        end
    end

endmodule

// File: rtl/issue_timing_ctrl_chk.sv
// Module: issue_timing_ctrl_chk
// Port-level properties of the issue timing controller, attached by bind.
module issue_timing_ctrl_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ins_valid,
    input logic             in_ready,
    input logic             stall,
    input logic             bubble,
    input logic             cancel,
    input logic [CNT_W-1:0] retired_cnt,
    input logic [CNT_W-1:0] cycle_cnt
);

    a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stall, bubble, cancel}));

    a_r2_held_no_take: assert property (@(posedge clk) disable iff (!rst_n)
        (stall || bubble) |-> !in_ready);

    a_r7_cancel_no_retire: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |=> retired_cnt == $past(retired_cnt));

    a_r1_retire_step: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !cancel) |=> retired_cnt == $past(retired_cnt) + CNT_W'(1));

    a_r13_cycle_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |=> cycle_cnt == $past(cycle_cnt) + CNT_W'(1));

endmodule

bind issue_timing_ctrl issue_timing_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .in_ready(in_ready),
    .stall(stall), .bubble(bubble), .cancel(cancel),
    .retired_cnt(retired_cnt), .cycle_cnt(cycle_cnt)
);

// File: tb/issue_timing_ctrl_test.sv
// Bench for issue_timing_ctrl: a table of descriptors with expected waits,
// then directed tests for reset, bus hold, empty cancel slots and variants.
module issue_timing_ctrl_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vld = 1'b0, late = 1'b0, tk = 1'b0, mp = 1'b0, busy = 1'b0;
    logic [3:0] cls = 4'd0;
    logic [4:0] sh = 5'd0;
    logic rdy, stl, bub, cxl, rdy_o, stl_o, bub_o, cxl_o;
    logic [31:0] ret, cyc, ret_o, cyc_o;
    logic watch_opt = 1'b0;
    int errors = 0, checks = 0;

    always #10 clk = ~clk;

    issue_timing_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ins_valid(vld), .ins_class(cls),
        .ins_uses_late(late), .br_taken(tk), .br_mispredict(mp),
        .shift_amt(sh), .bus_busy(busy), .in_ready(rdy), .stall(stl),
        .bubble(bub), .cancel(cxl), .retired_cnt(ret), .cycle_cnt(cyc));

    issue_timing_ctrl #(.FEATURE_MASK(6'b000100), .MULT_KIND(1)) uut_opt (
        .clk(clk), .rst_n(rst_n), .ins_valid(vld), .ins_class(cls),
        .ins_uses_late(late), .br_taken(tk), .br_mispredict(mp),
        .shift_amt(sh), .bus_busy(busy), .in_ready(rdy_o), .stall(stl_o),
        .bubble(bub_o), .cancel(cxl_o), .retired_cnt(ret_o), .cycle_cnt(cyc_o));

    // Entry: {class[15:12], uses_late[11], taken[10], mispredict[9], shamt[8:4], wait[3:0]}
    // wait = cycles from presentation until this entry is retired.
    localparam int N = 36;
    localparam logic [15:0] TBL [N] = '{
        {4'd0, 1'b0,1'b0,1'b0, 5'd0, 4'd1},  // R1 ALU
        {4'd8, 1'b0,1'b0,1'b0, 5'd0, 4'd1},  // load
        {4'd0, 1'b1,1'b0,1'b0, 5'd0, 4'd3},  // R3 two bubbles
        {4'd0, 1'b0,1'b0,1'b0, 5'd0, 4'd1},
        {4'd3, 1'b0,1'b1,1'b0, 5'd0, 4'd1},  // branch taken
        {4'd0, 1'b0,1'b0,1'b0, 5'd0, 4'd2},  // R4 taken = 2
        {4'd3, 1'b0,1'b0,1'b0, 5'd0, 4'd1},  // not taken
        {4'd0, 1'b0,1'b0,1'b0, 5'd0, 4'd1},  // R4 not taken = 1
        {4'd3, 1'b0,1'b1,1'b1, 5'd0, 4'd1},  // mispredict
        {4'd0, 1'b0,1'b0,1'b0, 5'd0, 4'd4},  // R7 three cancels
        {4'd4, 1'b0,1'b0,1'b0, 5'd0, 4'd1},  // direct call
        {4'd5, 1'b0,1'b0,1'b0, 5'd0, 4'd2},  // R5 call = 2
        {4'd0, 1'b0,1'b0,1'b0, 5'd0, 4'd3},  // R5 indirect = 3
        {4'd6, 1'b0,1'b0,1'b0, 5'd0, 4'd1},  // exception class
        {4'd0, 1'b0,1'b0,1'b0, 5'd0, 4'd4},  // R6 base = 4
        {4'd15,1'b0,1'b0,1'b0, 5'd5, 4'd1},  // shift by 5
        {4'd0, 1'b1,1'b0,1'b0, 5'd0, 4'd7},  // R10/R3 4 stalls + 2 bubbles
        {4'd10,1'b0,1'b0,1'b0, 5'd0, 4'd1},  // data line flush
        {4'd0, 1'b0,1'b0,1'b0, 5'd0, 4'd2},  // R8
        {4'd11,1'b0,1'b0,1'b0, 5'd0, 4'd1},  // data line init
        {4'd0, 1'b0,1'b0,1'b0, 5'd0, 4'd2},  // R8
        {4'd12,1'b0,1'b0,1'b0, 5'd0, 4'd1},  // icache flush
        {4'd0, 1'b0,1'b0,1'b0, 5'd0, 4'd4},  // R8
        {4'd13,1'b0,1'b0,1'b0, 5'd0, 4'd1},  // multiply
        {4'd0, 1'b0,1'b0,1'b0, 5'd0, 4'd3},  // R11 no dependency
        {4'd14,1'b0,1'b0,1'b0, 5'd0, 4'd1},  // divide
        {4'd0, 1'b1,1'b0,1'b0, 5'd0, 4'd8},  // R11/R3 5 stalls + 2 bubbles
        {4'd2, 1'b0,1'b0,1'b0, 5'd0, 4'd1},  // multicycle custom
        {4'd0, 1'b0,1'b0,1'b0, 5'd0, 4'd3},  // R11
        {4'd15,1'b0,1'b0,1'b0, 5'd0, 4'd1},  // shift by 0
        {4'd0, 1'b0,1'b0,1'b0, 5'd0, 4'd1},  // R10 minimum one
        {4'd7, 1'b0,1'b0,1'b0, 5'd0, 4'd1},  // control read
        {4'd1, 1'b0,1'b0,1'b0, 5'd0, 4'd1},  // R1 single custom, uses one gap cycle
        {4'd0, 1'b1,1'b0,1'b0, 5'd0, 4'd2},  // R3 one bubble left
        {4'd9, 1'b0,1'b0,1'b0, 5'd0, 4'd1},  // store
        {4'd0, 1'b0,1'b0,1'b0, 5'd0, 4'd1}   // R1
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Present one descriptor until retired; count cycles and cancels.
    task automatic issue(input logic [15:0] e, input int drop_at,
                         output int n, output int nc);
        logic done;
        cls = e[15:12]; late = e[11]; tk = e[10]; mp = e[9]; sh = e[8:4];
        vld = 1'b1; n = 0; nc = 0; done = 1'b0;
        while (!done && n < 200) begin
            #1;
            n++;
            if (watch_opt ? rdy_o : rdy) begin
                if (watch_opt ? cxl_o : cxl) nc++;
                else done = 1'b1;
            end
            @(negedge clk);
            if (n == drop_at) busy = 1'b0;
        end
        vld = 1'b0; late = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n, nc, sum, csum, r0;
        @(negedge clk);
        @(negedge clk);
        #1;
        check("R12 reset retired", int'(ret), 0);
        check("R12 reset cycles", int'(cyc), 0);
        check("R2 reset idle flags", {29'd0, stl, bub, cxl}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk.
        sum = 0; csum = 0;
        for (int i = 0; i < N; i++) begin
            issue(TBL[i], 0, n, nc);
            check($sformatf("table entry %0d wait", i), n, int'(TBL[i][3:0]));
            sum += n; csum += nc;
        end
        repeat (3) @(negedge clk);
        #1;
        check("R13 cycle count equals summed costs", int'(cyc), sum);
        check("R1 retired count", int'(ret), N);
        check("R7 cancelled slots", csum, 6);

        // R9: bus hold after a load.
        @(negedge clk);
        busy = 1'b1;
        issue({4'd8, 1'b0,1'b0,1'b0, 5'd0, 4'd1}, 0, n, nc);
        #1;
        check("R9 stall while bus busy", int'(stl), 1);
        issue({4'd0, 1'b0,1'b0,1'b0, 5'd0, 4'd0}, 3, n, nc);
        check("R9 wait until bus idle", n, 4);

        // R7: empty cancel slots raise no cancel and keep retired count.
        r0 = int'(ret);
        issue({4'd3, 1'b0,1'b1,1'b1, 5'd0, 4'd0}, 0, n, nc);
        for (int k = 0; k < 3; k++) begin
            #1;
            check("R7 empty slot no cancel", int'(cxl), 0);
            @(negedge clk);
        end
        issue({4'd0, 1'b0,1'b0,1'b0, 5'd0, 4'd0}, 0, n, nc);
        check("R7 window spent by empty slots", n, 1);
        #1;
        check("R7 retired after empty window", int'(ret), r0 + 2);

        // R12: reset drops a pending late-result hazard.
        issue({4'd8, 1'b0,1'b0,1'b0, 5'd0, 4'd0}, 0, n, nc);
        do_reset();
        #1;
        check("R12 retired cleared", int'(ret), 0);
        check("R12 cycles cleared", int'(cyc), 0);
        @(negedge clk);
        issue({4'd0, 1'b1,1'b0,1'b0, 5'd0, 4'd0}, 0, n, nc);
        check("R12 no bubble after reset", n, 1);

        // R6 and R10 variants on the instance with a feature bit set and
        // a logic-based multiplier.
        do_reset();
        watch_opt = 1'b1;
        issue({4'd6, 1'b0,1'b0,1'b0, 5'd0, 4'd0}, 0, n, nc);
        issue({4'd0, 1'b0,1'b0,1'b0, 5'd0, 4'd0}, 0, n, nc);
        check("R6 optional features cost five", n, 5);
        check("R6 three cancel slots", nc, 3);
        issue({4'd15, 1'b0,1'b0,1'b0, 5'd9, 4'd0}, 0, n, nc);
        issue({4'd0, 1'b0,1'b0,1'b0, 5'd0, 4'd0}, 0, n, nc);
        check("R10 logic multiplier shift = 2", n, 2);
        watch_opt = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule